// File: doc/BRIEF.md
# Parallel Flash Command-Sequence Controller

This block is a clocked model of a byte-wide parallel flash device. A host reads it like a plain read-only memory through active-low chip-enable, output-enable and write-enable pins. It changes the array only through short write sequences that unlock the device and then name a command. Two commands exist. Byte program clears bits at one address. Chip erase sets the array back to all ones. Each command runs for a fixed number of system-clock cycles, and `busy` is high for that whole time.

The three control pins are asynchronous. Each one passes through a two-flop synchroniser. A write strobe is the condition chip enable low, write enable low and output enable high. The address is taken when that strobe begins, which is when the later enable falls. The data byte is taken when the strobe ends, which is when the first enable rises. The sequence decoder is a state machine that moves once per completed strobe:

- **READ**: the idle state.
- **UNL1**: the first unlock byte has been seen.
- **UNL2**: both unlock bytes have been seen.
- **ERS_UNL0, ERS_UNL1, ERS_UNL2**: the erase set-up byte and the second unlock pair have been seen.
- **PGM_LOAD**: waiting for the target address and data.
- **PGM_BUSY and ERS_BUSY**: the timed operations.

Transitions:

- READ to UNL1 on AAh written to 5555h.
- UNL1 to UNL2 on 55h written to 2AAAh.
- UNL2 to ERS_UNL0 on 80h written to 5555h.
- UNL2 to PGM_LOAD on A0h written to 5555h.
- ERS_UNL0 to ERS_UNL1 on AAh written to 5555h.
- ERS_UNL1 to ERS_UNL2 on 55h written to 2AAAh.
- ERS_UNL2 to ERS_BUSY on 10h written to 5555h.
- PGM_LOAD to PGM_BUSY on any write.
- Either busy state back to READ when its timer expires. The array change is applied at that point.
- Any write that does not match the byte the current state expects returns the decoder to READ.

The array holds 64 bytes, indexed by the low six address bits. It is divided into regions:

| Region | Indices |
|---|---|
| Boot | 0 to 15 |
| Parameter, first | 16 to 23 |
| Parameter, second | 24 to 31 |
| Main, first | 32 to 47 |
| Main, second | 48 to 63 |

Top module: `pflash_ctrl`

## Requirements
- R1: After `rst_n` is released, `busy` is low and the data bus is not driven until a read condition is seen.
- R2: The bus carries the array byte at the low six address bits only while chip enable and output enable are low and write enable is high. The bus is released whenever chip enable or output enable is high.
- R3: For each write strobe, the address present when the strobe begins is used, and the data present when it ends is used. A change of address during the strobe has no effect.
- R4: The writes AAh at 5555h, 55h at 2AAAh and A0h at 5555h, followed by one address/data write, program that byte. The new value is the old value ANDed with the data, so programming can only turn bits from 1 to 0.
- R5: The six writes AAh at 5555h, 55h at 2AAAh, 80h at 5555h, AAh at 5555h, 55h at 2AAAh and 10h at 5555h start a chip erase. When `boot_lock` is low, the erase sets every byte to FFh.
- R6: When `boot_lock` is high at erase completion, indices 0 to 15 keep their contents and all other bytes become FFh.
- R7: `busy` rises after the last write of a command. It stays high for exactly PGM_CYCLES cycles for a program and ERS_CYCLES cycles for an erase, then the decoder is back in READ.
- R8: Every write during a chip erase is ignored. A program sequence issued then leaves its target at the erased value. A new sequence works normally once the erase ends.
- R9: A write that does not match the byte the current state expects returns the decoder to READ. No operation starts and the array is unchanged.
- R10: While `rst_n` is low, the bus is released and any operation in progress is dropped, so its target byte is unchanged. The same command works again after `rst_n` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; aborts operations |
| ce_n | input | 1 | Active-low chip enable (asynchronous) |
| oe_n | input | 1 | Active-low output enable (asynchronous) |
| we_n | input | 1 | Active-low write enable (asynchronous) |
| addr | input | ADDR_W | Byte address; commands decode all bits |
| data | inout | 8 | Bidirectional data bus |
| boot_lock | input | 1 | Protects indices 0 to 15 from chip erase |
| busy | output | 1 | High while a program or erase is timing |

## Verification
The checker assumes that the host keeps `addr` steady for at least three clock cycles after the later enable falls. It also assumes that the host holds `data` for at least three cycles after the first enable rises, because both are sampled after the two-flop synchronisers. The bench drives every pin on the falling clock edge and holds each one for four cycles around every enable change. Output enable is never lowered during a strobe. The busy-timing and command-ignore properties depend on those strobe edges being seen cleanly, so the stimulus creates no glitches or overlapping strobes.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNL1,
        ST_UNL2,
        ST_ERS_UNL0,
        ST_ERS_UNL1,
        ST_ERS_UNL2,
        ST_PGM_LOAD,
        ST_PGM_BUSY,
        ST_ERS_BUSY
    } fsm_state_e;

    localparam logic [15:0] UNLOCK_ADDR_A = 16'h5555;
    localparam logic [15:0] UNLOCK_ADDR_B = 16'h2AAA;
    localparam logic [7:0]  CODE_KEY_A    = 8'hAA;
    localparam logic [7:0]  CODE_KEY_B    = 8'h55;
    localparam logic [7:0]  CODE_ERS_SET  = 8'h80;
    localparam logic [7:0]  CODE_ERS_GO   = 8'h10;
    localparam logic [7:0]  CODE_PGM      = 8'hA0;

endpackage

// File: rtl/pflash_sync.sv
module pflash_sync #(
    parameter int          WIDTH   = 3,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL;
                stab_q <= RST_VAL;
            end else begin
                meta_q <= async_in[b];
                stab_q <= meta_q;
            end
        end
        assign sync_out[b] = stab_q;
    end
endmodule

// File: rtl/pflash_cmd_fsm.sv
module pflash_cmd_fsm
    import pflash_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int PGM_CYCLES = 20,
    parameter int ERS_CYCLES = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_evt,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output fsm_state_e        state,
    output logic              busy,
    output logic              pgm_commit,
    output logic              ers_commit,
    output logic [ADDR_W-1:0] pgm_addr,
    output logic [7:0]        pgm_data
);
    localparam int MAX_CYC = (PGM_CYCLES > ERS_CYCLES) ? PGM_CYCLES : ERS_CYCLES;
    localparam int CNT_W   = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;

    fsm_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                                 input logic [15:0] ea, input logic [7:0] ed);
        return (a == ADDR_W'(ea)) && (d == ed);
    endfunction

    // next-state decision
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_READ:     if (wr_evt) st_d = hit(wr_addr, wr_data, UNLOCK_ADDR_A, CODE_KEY_A) ? ST_UNL1 : ST_READ;
            ST_UNL1:     if (wr_evt) st_d = hit(wr_addr, wr_data, UNLOCK_ADDR_B, CODE_KEY_B) ? ST_UNL2 : ST_READ;
            ST_UNL2: begin
                if (wr_evt) begin
                    if (hit(wr_addr, wr_data, UNLOCK_ADDR_A, CODE_ERS_SET))   st_d = ST_ERS_UNL0;
                    else if (hit(wr_addr, wr_data, UNLOCK_ADDR_A, CODE_PGM))  st_d = ST_PGM_LOAD;
                    else                                                       st_d = ST_READ;
                end
            end
            ST_ERS_UNL0: if (wr_evt) st_d = hit(wr_addr, wr_data, UNLOCK_ADDR_A, CODE_KEY_A) ? ST_ERS_UNL1 : ST_READ;
            ST_ERS_UNL1: if (wr_evt) st_d = hit(wr_addr, wr_data, UNLOCK_ADDR_B, CODE_KEY_B) ? ST_ERS_UNL2 : ST_READ;
            ST_ERS_UNL2: if (wr_evt) st_d = hit(wr_addr, wr_data, UNLOCK_ADDR_A, CODE_ERS_GO) ? ST_ERS_BUSY : ST_READ;
            ST_PGM_LOAD: if (wr_evt) st_d = ST_PGM_BUSY;
            ST_PGM_BUSY: if (cnt_q == '0) st_d = ST_READ;
            ST_ERS_BUSY: if (cnt_q == '0) st_d = ST_READ;
            default:     st_d = ST_READ;
        endcase
    end

    // state register, timer and program latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_READ;
            cnt_q    <= '0;
            pgm_addr <= '0;
            pgm_data <= '1;
        end else begin
            st_q <= st_d;
            if (st_q == ST_PGM_LOAD && st_d == ST_PGM_BUSY) begin
                cnt_q    <= CNT_W'(PGM_CYCLES - 1);
                pgm_addr <= wr_addr;
                pgm_data <= wr_data;
            end else if (st_q != ST_ERS_BUSY && st_d == ST_ERS_BUSY) begin
                cnt_q <= CNT_W'(ERS_CYCLES - 1);
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        state      = st_q;
        busy       = (st_q == ST_PGM_BUSY) || (st_q == ST_ERS_BUSY);
        pgm_commit = (st_q == ST_PGM_BUSY) && (cnt_q == '0);
        ers_commit = (st_q == ST_ERS_BUSY) && (cnt_q == '0);
    end
endmodule

// File: rtl/pflash_array.sv
module pflash_array #(
    parameter int ARR_AW     = 6,
    parameter int BOOT_DEPTH = 16
) (
    input  logic              clk,
    input  logic [ARR_AW-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              pgm_en,
    input  logic [ARR_AW-1:0] pgm_addr,
    input  logic [7:0]        pgm_data,
    input  logic              ers_en,
    input  logic              lock
);
    localparam int DEPTH = 1 << ARR_AW;

    logic [7:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        localparam bit IS_BOOT = (i < BOOT_DEPTH);
        always_ff @(posedge clk) begin
            if (ers_en) begin
                if (!(IS_BOOT && lock)) mem[i] <= 8'hFF;
            end else if (pgm_en && pgm_addr == ARR_AW'(i)) begin
                mem[i] <= mem[i] & pgm_data;
            end
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/pflash_ctrl.sv
module pflash_ctrl
    import pflash_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int ARR_AW     = 6,
    parameter int BOOT_DEPTH = 16,
    parameter int PGM_CYCLES = 20,
    parameter int ERS_CYCLES = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    inout  wire  [7:0]        data,
    input  logic              boot_lock,
    output logic              busy
);
    logic [2:0]        ctl_s;
    logic              ce_s, oe_s, we_s;
    logic              strobe, strobe_q, wr_evt;
    logic [ADDR_W-1:0] addr_l;
    logic              rd_drive;
    logic [7:0]        rd_data;
    fsm_state_e        fsm_state;
    logic              pgm_commit, ers_commit;
    logic [ADDR_W-1:0] pgm_addr;
    logic [7:0]        pgm_data;

    pflash_sync #(.WIDTH(3), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_in({ce_n, oe_n, we_n}), .sync_out(ctl_s)
    );
    assign {ce_s, oe_s, we_s} = ctl_s;

    assign strobe = !ce_s && !we_s && oe_s;
    assign wr_evt = strobe_q && !strobe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            addr_l   <= '0;
        end else begin
            strobe_q <= strobe;
            if (strobe && !strobe_q) addr_l <= addr;
        end
    end

    pflash_cmd_fsm #(.ADDR_W(ADDR_W), .PGM_CYCLES(PGM_CYCLES), .ERS_CYCLES(ERS_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_addr(addr_l), .wr_data(data),
        .state(fsm_state), .busy(busy), .pgm_commit(pgm_commit), .ers_commit(ers_commit),
        .pgm_addr(pgm_addr), .pgm_data(pgm_data)
    );

    pflash_array #(.ARR_AW(ARR_AW), .BOOT_DEPTH(BOOT_DEPTH)) u_array (
        .clk(clk), .rd_addr(addr[ARR_AW-1:0]), .rd_data(rd_data),
        .pgm_en(pgm_commit), .pgm_addr(pgm_addr[ARR_AW-1:0]), .pgm_data(pgm_data),
        .ers_en(ers_commit), .lock(boot_lock)
    );

    assign rd_drive = rst_n && !ce_s && !oe_s && we_s;
    assign data     = rd_drive ? rd_data : 8'bz;
endmodule

// File: rtl/pflash_ctrl_chk.sv
module pflash_ctrl_chk
    import pflash_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       wr_evt,
    input logic       rd_drive,
    input fsm_state_e state,
    input logic       pgm_commit,
    input logic       ers_commit
);
    // R10
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_release_rst_chk: assert (!rd_drive);
        end
    end

    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_evt));

    // R7
    pgm_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_commit |=> (!busy && state == ST_READ));

    // R7
    ers_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ers_commit |=> (!busy && state == ST_READ));

    // R8
    erase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERS_BUSY && !ers_commit) |=> (state == ST_ERS_BUSY));
endmodule

bind pflash_ctrl pflash_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .wr_evt(wr_evt), .rd_drive(rd_drive),
    .state(fsm_state), .pgm_commit(pgm_commit), .ers_commit(ers_commit)
);

// File: tb/pflash_ctrl_test.sv
`timescale 1ns/1ps
module pflash_ctrl_test;
    localparam int PGM_CYC = 20;
    localparam int ERS_CYC = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [15:0] addr = '0;
    logic        boot_lock = 1'b0;
    logic        busy;
    logic        tb_drv = 1'b0;
    logic [7:0]  tb_dout = '0;
    wire  [7:0]  data;

    int n_total = 0;
    int n_fail  = 0;
    int busy_run = 0;
    int busy_len = 0;

    always #2 clk = ~clk;

    assign data = tb_drv ? tb_dout : 8'bz;
    for (genvar i = 0; i < 8; i++) begin : g_pd
        pulldown (data[i]);
    end

    pflash_ctrl #(.PGM_CYCLES(PGM_CYC), .ERS_CYCLES(ERS_CYC)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .data(data), .boot_lock(boot_lock), .busy(busy)
    );

    always @(negedge clk) begin
        if (busy) busy_run <= busy_run + 1;
        else if (busy_run != 0) begin
            busy_len <= busy_run;
            busy_run <= 0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_swap(input logic [15:0] a, input logic [15:0] a2, input logic [7:0] d);
        @(negedge clk); addr = a; oe_n = 1'b1; tb_dout = d; tb_drv = 1'b1;
        @(negedge clk); we_n = 1'b0;
        @(negedge clk); ce_n = 1'b0;
        repeat (5) @(negedge clk);
        addr = a2;
        repeat (2) @(negedge clk);
        we_n = 1'b1;
        repeat (4) @(negedge clk);
        ce_n = 1'b1; tb_drv = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        wr_swap(a, a, d);
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
        repeat (4) @(negedge clk);
        d = data;
        ce_n = 1'b1; oe_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_idle();
        int t = 0;
        repeat (2) @(negedge clk);
        while (busy && t < 4 * ERS_CYC) begin @(negedge clk); t++; end
        repeat (2) @(negedge clk);
    endtask

    task automatic seq_program(input logic [15:0] a, input logic [7:0] d);
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'hA0); wr(a, d);
    endtask

    task automatic seq_erase();
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h80);
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h10);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 busy after reset", busy, 0);
        check("R1 bus released after reset", data, 0);
    endtask

    task automatic t_erase_all();
        int bad = 0;
        logic [7:0] v;
        boot_lock = 1'b0; busy_len = 0;
        seq_erase();
        wait_idle();
        check("R7 erase busy length", busy_len, ERS_CYC);
        for (int i = 0; i < 64; i++) begin
            rd(16'(i), v);
            if (v != 8'hFF) bad++;
        end
        check("R5 erased bytes not FF", bad, 0);
    endtask

    task automatic t_program();
        logic [7:0] v;
        busy_len = 0;
        seq_program(16'h0021, 8'h5A);
        wait_idle();
        check("R7 program busy length", busy_len, PGM_CYC);
        rd(16'h0021, v); check("R4 program 5A", v, 8'h5A);
        seq_program(16'h0021, 8'hF0);
        wait_idle();
        rd(16'h0021, v); check("R4 program only clears bits", v, 8'h50);
    endtask

    task automatic t_read_gate();
        @(negedge clk); addr = 16'h0021; ce_n = 1'b0; oe_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R2 oe high releases bus", data, 0);
        ce_n = 1'b1; oe_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R2 ce high releases bus", data, 0);
        ce_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R2 read drives array byte", data, 8'h50);
        ce_n = 1'b1; oe_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_frame();
        logic [7:0] v;
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'hA0);
        wr_swap(16'h0030, 16'h0031, 8'h3C);
        wait_idle();
        rd(16'h0030, v); check("R3 address taken at strobe start", v, 8'h3C);
        rd(16'h0031, v); check("R3 late address unused", v, 8'hFF);
    endtask

    task automatic t_bad_seq();
        logic [7:0] v;
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h56);
        wr(16'h5555, 8'hA0); wr(16'h0032, 8'h00);
        repeat (4) @(negedge clk);
        check("R9 no busy after mismatch", busy, 0);
        rd(16'h0032, v); check("R9 array unchanged after mismatch", v, 8'hFF);
    endtask

    task automatic t_lock();
        logic [7:0] v;
        seq_program(16'h0005, 8'h00); wait_idle();
        seq_program(16'h0033, 8'h00); wait_idle();
        seq_program(16'h0012, 8'h00); wait_idle();
        boot_lock = 1'b1;
        seq_erase(); wait_idle();
        rd(16'h0005, v); check("R6 boot byte kept", v, 8'h00);
        rd(16'h0033, v); check("R6 main byte erased", v, 8'hFF);
        rd(16'h0012, v); check("R6 parameter byte erased", v, 8'hFF);
        boot_lock = 1'b0;
    endtask

    task automatic t_ignore();
        logic [7:0] v;
        seq_program(16'h0034, 8'h00); wait_idle();
        seq_erase();
        seq_program(16'h0034, 8'h00);
        check("R8 still erasing during commands", busy, 1);
        wait_idle();
        rd(16'h0034, v); check("R8 program during erase ignored", v, 8'hFF);
        seq_program(16'h0034, 8'h12); wait_idle();
        rd(16'h0034, v); check("R8 program after erase works", v, 8'h12);
    endtask

    task automatic t_reset_abort();
        logic [7:0] v;
        int t = 0;
        seq_program(16'h0035, 8'h00);
        while (!busy && t < 20) begin @(negedge clk); t++; end
        rst_n = 1'b0;
        addr = 16'h0035; ce_n = 1'b0; oe_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R10 bus released in reset", data, 0);
        check("R10 busy dropped in reset", busy, 0);
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);
        rd(16'h0035, v); check("R10 aborted program left byte", v, 8'hFF);
        seq_program(16'h0035, 8'h00); wait_idle();
        rd(16'h0035, v); check("R10 reissued program", v, 8'h00);
    endtask

    initial begin
        t_reset();
        t_erase_all();
        t_program();
        t_read_gate();
        t_frame();
        t_bad_seq();
        t_lock();
        t_ignore();
        t_reset_abort();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule